// File: doc/BRIEF.md
# SPI Register-Access Slave Front End

This block is the serial side of a peripheral whose configuration lives in a small register file. A master selects it by pulling the chip-select line low. While the peripheral core is not yet ready, the data-out line is held high. Once the core is ready, the line goes low, and the master may start clocking. The first byte the master sends is a command header. Its top bit chooses read or write, the next bit chooses a single or an auto-incrementing access, and the low six bits hold the register address. While the header is being clocked in, the block returns a status byte whose top bit is zero.

Data bytes follow the header. Each written byte reaches the register file as a one-cycle write strobe, together with the address and the data. For reads, the block fetches the addressed register and returns it on the next byte. In burst mode the address advances after every data byte and wraps from the top of the six-bit space back to zero. If chip select rises before a byte is complete, that byte is discarded and nothing is committed.

All serial inputs are brought into the system clock domain through synchronisers, and every edge is detected there. The system clock must therefore run several times faster than the serial clock.

Top module: `spi_regport_slave`

## Requirements
- R1: Serial bits travel most significant bit first; data-in is sampled on the rising serial clock edge, and data-out changes only after a falling edge (mode 0).
- R2: Header bit 7 set to 1 means read and 0 means write, bit 6 set to 1 selects burst, and bits 5..0 give the starting register address.
- R3: After chip select falls, data-out is driven high until `core_ready` is seen high; only then does it fall to the first status bit, which is 0.
- R4: When `core_ready` is already high, data-out goes low within 6 system clock cycles of chip select falling.
- R5: During the header byte, and during each write data byte, the block shifts out a status byte: bit 7 is 0 and bits 6..0 equal `core_status`.
- R6: A single write gives exactly one `reg_we` pulse, carrying the header address and the received byte; further bytes in the same selection write nothing.
- R7: A single read returns the register at the header address on the byte after the header; later bytes in the same selection return the status byte.
- R8: In burst mode the address increases by one after every data byte, for reads and writes alike, and wraps from 0x3F to 0x00.
- R9: If chip select rises before the eighth bit of a header or data byte, no write is committed, and the next selection decodes a fresh header.
- R10: `spi_miso_oe` is 0 while chip select is high and 1 while the block is selected.
- R11: After reset, `spi_miso_oe` and `reg_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the data-out pad (0 = high impedance) |
| core_ready | input | 1 | Peripheral core is ready for access |
| core_status | input | 7 | Status bits returned in bits 6..0 of the status byte |
| reg_addr | output | 6 | Register file address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational from the register file |

## Verification
The header decode is exercised with four command shapes. These are a single write, a single read, a burst write that starts at 0x3E, and a burst read that starts at 0x3F. Together they separate a wrong read/write bit, a wrong burst bit, a missing address increment and a missing wrap at the top of the address space. The ready handshake is tried twice: once with the core held not ready, where data-out must stay high, and once with the core already ready, where the fall must come within a few cycles. Aborts are placed mid-header and mid-data. A following clean read shows both that no write was committed and that the header decoder restarted.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_HOLD
  } rp_state_e;

  localparam int unsigned HDR_RD_BIT    = 7;
  localparam int unsigned HDR_BURST_BIT = 6;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0][STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[g] <= {STAGES{RST_VAL[g]}};
        end else begin
          chain_q[g] <= {chain_q[g][STAGES-2:0], async_in[g]};
        end
      end
      assign sync_out[g] = chain_q[g][STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level_in;
    end
  end

  assign rise = level_in & ~prev_q;
  assign fall = ~level_in & prev_q;

endmodule

// File: rtl/spi_regport_rxshift.sv
module spi_regport_rxshift #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_done,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    shift_d = shift_q;
    byte_d  = byte_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (sample) begin
      shift_d = {shift_q[DATA_W-2:0], din};
      cnt_d   = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        byte_d = {shift_q[DATA_W-2:0], din};
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      byte_q  <= byte_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign byte_out  = byte_q;
  assign byte_done = done_q;
  assign bit_cnt   = cnt_q;

endmodule

// File: rtl/spi_regport_txshift.sv
module spi_regport_txshift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              msb
);

  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      sh_d = {sh_q[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign msb = sh_q[DATA_W-1];

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = DATA_W - 2,
  localparam int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              core_ready,
  input  logic [DATA_W-2:0] core_status,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              shift_en,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_val,
  output logic              tx_shift,
  output logic              force_high,
  output logic              drive,
  output logic              burst,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we
);

  rp_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              burst_q, burst_d;
  logic [DATA_W-1:0] status_byte;
  logic              active;

  assign status_byte = {1'b0, core_status};
  assign active = (state_q == ST_HDR) || (state_q == ST_DATA) || (state_q == ST_HOLD);

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    rd_d     = rd_q;
    burst_d  = burst_q;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    tx_val   = status_byte;

    unique case (state_q)
      ST_IDLE: begin
        if (!csn_s) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (core_ready) begin
          state_d = ST_HDR;
          tx_load = 1'b1;
        end
      end
      ST_HDR: begin
        if (byte_done) begin
          rd_d    = rx_byte[HDR_RD_BIT];
          burst_d = rx_byte[HDR_BURST_BIT];
          addr_d  = rx_byte[ADDR_W-1:0];
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (byte_done) begin
          if (burst_q) begin
            addr_d = addr_q + 1'b1;
          end else begin
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        state_d = ST_HOLD;
      end
      default: state_d = ST_IDLE;
    endcase

    if (active && sclk_fall) begin
      if (bit_cnt == '0) begin
        tx_load = 1'b1;
        tx_val  = ((state_q == ST_DATA) && rd_q) ? reg_rdata : status_byte;
      end else begin
        tx_shift = 1'b1;
      end
    end

    if (csn_s) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      burst_q <= burst_d;
    end
  end

  assign shift_en   = active;
  assign force_high = (state_q == ST_WAIT);
  assign drive      = (state_q != ST_IDLE);
  assign burst      = burst_q;
  assign reg_addr   = addr_q;
  assign reg_wdata  = rx_byte;
  assign reg_we     = (state_q == ST_DATA) && byte_done && !rd_q;

endmodule

// File: rtl/spi_regport_slave.sv
module spi_regport_slave #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W = DATA_W - 2,
  localparam int unsigned CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              core_ready,
  input  logic [DATA_W-2:0] core_status,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [2:0]        pins_s;
  logic              csn_s, sclk_s, mosi_s;
  logic              sclk_rise, sclk_fall;
  logic              shift_en, byte_done;
  logic [DATA_W-1:0] rx_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic              tx_load, tx_shift, tx_msb;
  logic [DATA_W-1:0] tx_val;
  logic              force_high, drive, burst_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  spi_regport_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_in({spi_csn, spi_sclk, spi_mosi}),
    .sync_out(pins_s)
  );
  assign csn_s  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_regport_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .level_in(sclk_s),
    .rise    (sclk_rise),
    .fall    (sclk_fall)
  );

  spi_regport_rxshift #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .enable   (shift_en),
    .sample   (sclk_rise),
    .din      (mosi_s),
    .byte_out (rx_byte),
    .byte_done(byte_done),
    .bit_cnt  (bit_cnt)
  );

  spi_regport_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .csn_s      (csn_s),
    .core_ready (core_ready),
    .core_status(core_status),
    .byte_done  (byte_done),
    .rx_byte    (rx_byte),
    .bit_cnt    (bit_cnt),
    .sclk_fall  (sclk_fall),
    .reg_rdata  (reg_rdata),
    .shift_en   (shift_en),
    .tx_load    (tx_load),
    .tx_val     (tx_val),
    .tx_shift   (tx_shift),
    .force_high (force_high),
    .drive      (drive),
    .burst      (burst_w),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we)
  );

  spi_regport_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load    (tx_load),
    .load_val(tx_val),
    .shift   (tx_shift),
    .msb     (tx_msb)
  );

  assign spi_miso    = force_high | tx_msb;
  assign spi_miso_oe = drive;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_s,
  input logic              miso,
  input logic              miso_oe,
  input logic              reg_we,
  input logic              burst,
  input logic [ADDR_W-1:0] reg_addr
);

  // R10
  tristate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso_oe);

  // R3
  wait_so_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> miso);

  // R6
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && burst) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));

  // R9
  we_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(!csn_s));

endmodule

bind spi_regport_slave spi_regport_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csn_s   (csn_s),
  .miso    (spi_miso),
  .miso_oe (spi_miso_oe),
  .reg_we  (reg_we),
  .burst   (burst_w),
  .reg_addr(reg_addr)
);

// File: tb/spi_regport_slave_test.sv
module spi_regport_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 10;

  logic       clk, rst_n;
  logic       sclk, csn, mosi;
  logic       miso, miso_oe;
  logic       core_ready;
  logic [6:0] core_status;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;

  logic [7:0] mem [64];
  int         we_cnt;
  int         checks, failures;
  bit         done;

  spi_regport_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .core_ready(core_ready),
    .core_status(core_status), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'h5C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
      we_cnt <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
  end
  assign reg_rdata = mem[reg_addr];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic spi_select(output int cycles);
    cycles = -1;
    @(negedge clk) csn = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (miso_oe && !miso) begin
        cycles = k + 1;
        break;
      end
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic spi_deselect();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_one(input logic [5:0] a, output logic [7:0] d);
    int c;
    logic [7:0] r;
    spi_select(c);
    spi_byte({2'b10, a}, r);
    spi_byte(8'h00, d);
    spi_deselect();
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", miso_oe, 0);
    chk("R11 we after reset", reg_we, 0);
    chk("R10 oe with csn high", miso_oe, 0);
  endtask

  task automatic t_wait_ready();
    int c;
    logic [7:0] r, d;
    core_ready = 1'b0;
    @(negedge clk) csn = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 oe while selected", miso_oe, 1);
    chk("R3 SO high while not ready", miso, 1);
    core_ready = 1'b1;
    c = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!miso) begin c = k + 1; break; end
    end
    chk("R3 SO falls after ready", (c > 0 && c <= 4), 1);
    spi_byte(8'h85, r);
    spi_byte(8'h00, d);
    spi_deselect();
    chk("R7 read after wait", d, init_val(5));
    chk("R10 oe after deselect", miso_oe, 0);
  endtask

  task automatic t_fast_ready();
    int c;
    logic [7:0] r;
    core_status = 7'h5A;
    spi_select(c);
    chk("R4 SO low latency", (c > 0 && c <= 6), 1);
    spi_byte(8'h20, r);
    chk("R5 status during header", r, 8'h5A);
    spi_deselect();
  endtask

  task automatic t_single_write();
    int c, w0;
    logic [7:0] r, d;
    core_status = 7'h33;
    w0 = we_cnt;
    spi_select(c);
    spi_byte(8'h05, r);
    chk("R1 status header bits msb first", r, 8'h33);
    spi_byte(8'hA5, r);
    chk("R5 status during write data", r, 8'h33);
    spi_byte(8'h5B, r);
    spi_deselect();
    chk("R6 one write pulse", we_cnt - w0, 1);
    chk("R6 write data at addr 5", mem[5], 8'hA5);
    chk("R6 extra byte not written to 6", mem[6], init_val(6));
    read_one(6'h05, d);
    chk("R2 read bit decode", d, 8'hA5);
  endtask

  task automatic t_single_read();
    int c;
    logic [7:0] r, d1, d2;
    core_status = 7'h11;
    spi_select(c);
    spi_byte(8'h80 | 8'h09, r);
    spi_byte(8'h00, d1);
    spi_byte(8'h00, d2);
    spi_deselect();
    chk("R7 single read data", d1, init_val(9));
    chk("R7 byte after single read is status", d2, 8'h11);
  endtask

  task automatic t_burst();
    int c, w0;
    logic [7:0] r, d;
    logic [7:0] wv [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    w0 = we_cnt;
    spi_select(c);
    spi_byte(8'h7E, r);
    foreach (wv[i]) spi_byte(wv[i], r);
    spi_deselect();
    chk("R8 burst write count", we_cnt - w0, 4);
    chk("R8 burst 0x3E", mem[6'h3E], 8'h11);
    chk("R8 burst 0x3F", mem[6'h3F], 8'h22);
    chk("R8 burst wrap 0x00", mem[0], 8'h33);
    chk("R8 burst wrap 0x01", mem[1], 8'h44);
    chk("R2 burst address start", mem[6'h3D], init_val(6'h3D));
    spi_select(c);
    spi_byte(8'hFF, r);
    spi_byte(8'h00, d);
    chk("R8 burst read 0x3F", d, 8'h22);
    spi_byte(8'h00, d);
    chk("R8 burst read wrap 0x00", d, 8'h33);
    spi_byte(8'h00, d);
    chk("R8 burst read 0x01", d, 8'h44);
    spi_deselect();
  endtask

  task automatic t_abort();
    int c, w0;
    logic [7:0] r, d;
    w0 = we_cnt;
    spi_select(c);
    spi_byte(8'h0A, r);
    spi_bits(8'hFF, 4, r);
    spi_deselect();
    chk("R9 no write on data abort", we_cnt - w0, 0);
    spi_select(c);
    spi_bits(8'h0A, 3, r);
    spi_deselect();
    read_one(6'h0A, d);
    chk("R9 register intact after abort", d, init_val(10));
    chk("R9 no write on header abort", we_cnt - w0, 0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    sclk = 0; csn = 1; mosi = 0; core_ready = 1; core_status = '0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset();
    t_wait_ready();
    t_fast_ready();
    t_single_write();
    t_single_read();
    t_burst();
    t_abort();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

endmodule